// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store of a 32-bit processor that runs in one of seven modes: an unprivileged mode, a privileged mode that shares its registers, and five exception modes. Sixteen register indices are visible at any time. Indices 0 to 7 reach one shared set of physical registers. Indices 8 to 14 reach a physical copy that belongs to the current mode's bank. Index 15 is the program counter. By convention index 13 is the stack pointer and index 14 is the link register that holds a return address.

The block also holds the current status word and one saved status word for each exception mode. The current mode is the low five bits of the status word, and bit 5 selects 16-bit instruction state. An exception-entry strobe does three things on one clock edge: it copies the status word into the target mode's saved slot, switches the mode, and writes the return address into the target bank's link register. A return strobe restores the status word from the saved slot of the current mode. The program counter has its own load and increment inputs. Decode, arithmetic and vector fetch are left to the surrounding pipeline.

Top module: `bnk_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, the status word becomes 0x00000013 (Supervisor, bit 5 clear), both read outputs become 0 and `pc_out` becomes `RESET_PC` (default 0).
- R2: Indices 0 to 7 name the same physical register in every mode.
- R3: Indices 8 to 14 name a separate physical register in each of six banks: one for User/System and one each for FIQ, IRQ, Supervisor, Abort and Undef.
- R4: System mode reaches exactly the same registers as User mode.
- R5: Each read port registers its data, so data appears one cycle after the index is presented. The data is the value held before that edge, so a same-cycle write is not bypassed. Index 15 reads the program counter.
- R6: A register write to index 15 has no effect.
- R7: When `exc_go` is high and `exc_mode` names an exception mode, one edge does all of the following: the old status word goes into that mode's saved slot, the mode field takes `exc_mode` while the other status bits are kept, and that mode's index 14 takes `exc_ret_addr`. This has priority over return and status writes. A register write in the same cycle uses the old mode's bank, and the return address wins if both target the same register.
- R8: An `exc_go` whose `exc_mode` is User, System or not a legal code has no effect.
- R9: `eret_go` in an exception mode loads the status word from that mode's saved slot. In User or System mode it has no effect. It has priority over a status write.
- R10: The mode codes are User 0x10, FIQ 0x11, IRQ 0x12, Supervisor 0x13, Abort 0x17, Undef 0x1B and System 0x1F, held in status bits 4:0. A status write (`sr_wr_en`) takes all of `sr_wr_data`, except that an illegal mode code keeps the previous mode field.
- R11: `pc_load` loads `pc_load_val` and takes priority over `pc_inc`. `pc_inc` adds 4 when status bit 5 is clear and adds 2 when it is set, using the status value before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_b_idx | input | 4 | Read port B register index |
| rd_a_data | output | 32 | Read port A data, registered |
| rd_b_data | output | 32 | Read port B data, registered |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| sr_wr_en | input | 1 | Status word write strobe |
| sr_wr_data | input | 32 | Status word write data |
| exc_go | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Target mode of the exception |
| exc_ret_addr | input | 32 | Return address written to the target link register |
| eret_go | input | 1 | Return-from-exception strobe |
| pc_load | input | 1 | Program counter load strobe |
| pc_load_val | input | 32 | Program counter load value |
| pc_inc | input | 1 | Program counter step strobe |
| cur_status | output | 32 | Current status word |
| pc_out | output | 32 | Program counter |

## Verification
Distinct values are written into the low registers once, and into the upper registers once per mode. Reading them back from other modes then tells shared storage apart from banked storage, and shows whether System aliases User or has a bank of its own. A write and a read of the same register in one cycle shows whether the read port bypasses. An exception entry with a write to the old bank's link register in the same cycle shows which bank each write lands in. Nested entries followed by returns, entries to non-exception targets, and returns from unprivileged modes separate correct status saving from a restore taken from the wrong slot. A long random phase mixes all strobes, so the priority among them is tried against the reference model on every clock.

// File: rtl/bnk_pkg.sv
package bnk_pkg;
  localparam int MODE_W = 5;
  localparam int BANK_W = 3;
  localparam int N_BANKS = 6;
  localparam int T_BIT = 5;

  localparam logic [MODE_W-1:0] M_USR = 5'h10;
  localparam logic [MODE_W-1:0] M_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] M_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] M_SVC = 5'h13;
  localparam logic [MODE_W-1:0] M_ABT = 5'h17;
  localparam logic [MODE_W-1:0] M_UND = 5'h1B;
  localparam logic [MODE_W-1:0] M_SYS = 5'h1F;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // bank 0 is the unprivileged bank; 1..5 belong to exception modes
  function automatic logic [BANK_W-1:0] mode_bank(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   return 3'd1;
      M_IRQ:   return 3'd2;
      M_SVC:   return 3'd3;
      M_ABT:   return 3'd4;
      M_UND:   return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic mode_has_saved(input logic [MODE_W-1:0] m);
    return mode_legal(m) && (mode_bank(m) != 3'd0);
  endfunction
endpackage

// File: rtl/bnk_map.sv
module bnk_map
  import bnk_pkg::*;
#(
  parameter int SHARED    = 8,
  parameter int BANK_REGS = 7,
  parameter int IDX_W     = 4,
  parameter int PHYS_W    = 6
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys,
  output logic              is_pc
);
  localparam int PC_IDX = SHARED + BANK_REGS;

  always_comb begin
    if (int'(idx) < SHARED)
      phys = PHYS_W'(int'(idx));
    else
      phys = PHYS_W'(SHARED + int'(mode_bank(mode)) * BANK_REGS + (int'(idx) - SHARED));
    is_pc = (int'(idx) == PC_IDX);
  end
endmodule

// File: rtl/bnk_status.sv
module bnk_status
  import bnk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_go,
  input  logic [MODE_W-1:0] exc_mode,
  input  logic              eret_go,
  input  logic              sr_wr_en,
  input  logic [DATA_W-1:0] sr_wr_data,
  output logic [DATA_W-1:0] cur,
  output logic              exc_take
);
  localparam int N_SAVED = N_BANKS - 1;
  localparam logic [DATA_W-1:0] RST_STATUS = DATA_W'(M_SVC);

  logic [DATA_W-1:0] saved [N_SAVED];
  logic [DATA_W-1:0] saved_sel;
  logic              ret_take;
  logic [MODE_W-1:0] cur_mode;

  assign cur_mode = cur[MODE_W-1:0];
  assign exc_take = exc_go && mode_has_saved(exc_mode);
  assign ret_take = eret_go && mode_has_saved(cur_mode);

  always_comb begin
    saved_sel = RST_STATUS;
    for (int s = 0; s < N_SAVED; s++)
      if (mode_bank(cur_mode) == BANK_W'(s + 1)) saved_sel = saved[s];
  end

  for (genvar s = 0; s < N_SAVED; s++) begin : g_saved
    always_ff @(posedge clk) begin
      if (rst)
        saved[s] <= RST_STATUS;
      else if (exc_take && mode_bank(exc_mode) == BANK_W'(s + 1))
        saved[s] <= cur;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cur <= RST_STATUS;
    else if (exc_take)
      cur <= {cur[DATA_W-1:MODE_W], exc_mode};
    else if (ret_take)
      cur <= saved_sel;
    else if (sr_wr_en)
      cur <= mode_legal(sr_wr_data[MODE_W-1:0]) ? sr_wr_data
                                                 : {sr_wr_data[DATA_W-1:MODE_W], cur_mode};
  end
endmodule

// File: rtl/bnk_pc.sv
module bnk_pc #(
  parameter int               DATA_W   = 32,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              inc,
  input  logic              half_step,
  output logic [DATA_W-1:0] pc
);
  localparam logic [DATA_W-1:0] STEP_WIDE = DATA_W'(4);
  localparam logic [DATA_W-1:0] STEP_NARROW = DATA_W'(2);

  always_ff @(posedge clk) begin
    if (rst)       pc <= RESET_PC;
    else if (load) pc <= load_val;
    else if (inc)  pc <= pc + (half_step ? STEP_NARROW : STEP_WIDE);
  end
endmodule

// File: rtl/bnk_regfile.sv
module bnk_regfile
  import bnk_pkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter int               IDX_W     = 4,
  parameter int               SHARED    = 8,
  parameter int               BANK_REGS = 7,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sr_wr_en,
  input  logic [DATA_W-1:0] sr_wr_data,
  input  logic              exc_go,
  input  logic [MODE_W-1:0] exc_mode,
  input  logic [DATA_W-1:0] exc_ret_addr,
  input  logic              eret_go,
  input  logic              pc_load,
  input  logic [DATA_W-1:0] pc_load_val,
  input  logic              pc_inc,
  output logic [DATA_W-1:0] cur_status,
  output logic [DATA_W-1:0] pc_out
);
  localparam int PHYS_N = SHARED + BANK_REGS * N_BANKS;
  localparam int PHYS_W = $clog2(PHYS_N);
  localparam int N_RD   = 2;
  localparam int LR_IDX = SHARED + BANK_REGS - 1;

  logic [DATA_W-1:0] regs [PHYS_N];
  logic [MODE_W-1:0] mode;
  logic              exc_take;
  logic [PHYS_W-1:0] wr_phys, lr_phys;
  logic              wr_is_pc, lr_is_pc;
  logic              wr_take;

  logic [IDX_W-1:0]  rd_idx  [N_RD];
  logic [PHYS_W-1:0] rd_phys [N_RD];
  logic              rd_pc   [N_RD];
  logic [DATA_W-1:0] rd_q    [N_RD];

  assign mode = cur_status[MODE_W-1:0];

  bnk_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst), .exc_go(exc_go), .exc_mode(exc_mode),
    .eret_go(eret_go), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
    .cur(cur_status), .exc_take(exc_take)
  );

  bnk_pc #(.DATA_W(DATA_W), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst(rst), .load(pc_load), .load_val(pc_load_val),
    .inc(pc_inc), .half_step(cur_status[T_BIT]), .pc(pc_out)
  );

  bnk_map #(.SHARED(SHARED), .BANK_REGS(BANK_REGS), .IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_wmap (
    .mode(mode), .idx(wr_idx), .phys(wr_phys), .is_pc(wr_is_pc)
  );

  bnk_map #(.SHARED(SHARED), .BANK_REGS(BANK_REGS), .IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_lrmap (
    .mode(exc_mode), .idx(IDX_W'(LR_IDX)), .phys(lr_phys), .is_pc(lr_is_pc)
  );

  assign wr_take = wr_en && !wr_is_pc;

  // storage without reset; the link-register write is placed last so it wins a collision
  always_ff @(posedge clk) begin
    if (wr_take)  regs[wr_phys] <= wr_data;
    if (exc_take && !lr_is_pc) regs[lr_phys] <= exc_ret_addr;
  end

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    bnk_map #(.SHARED(SHARED), .BANK_REGS(BANK_REGS), .IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_rmap (
      .mode(mode), .idx(rd_idx[p]), .phys(rd_phys[p]), .is_pc(rd_pc[p])
    );
    always_ff @(posedge clk) begin
      if (rst)           rd_q[p] <= '0;
      else if (rd_pc[p]) rd_q[p] <= pc_out;
      else               rd_q[p] <= regs[rd_phys[p]];
    end
  end

  assign rd_a_data = rd_q[0];
  assign rd_b_data = rd_q[1];
endmodule

// File: rtl/bnk_regfile_chk.sv
module bnk_regfile_chk
  import bnk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              exc_go,
  input logic [MODE_W-1:0] exc_mode,
  input logic              eret_go,
  input logic              sr_wr_en,
  input logic [DATA_W-1:0] sr_wr_data,
  input logic              pc_load,
  input logic [DATA_W-1:0] pc_load_val,
  input logic              pc_inc,
  input logic [DATA_W-1:0] cur_status,
  input logic [DATA_W-1:0] pc_out
);
  localparam logic [DATA_W-1:0] STEP_WIDE = DATA_W'(4);
  localparam logic [DATA_W-1:0] STEP_NARROW = DATA_W'(2);

  logic prev_rst = 1'b0;
  always_ff @(posedge clk) prev_rst <= rst;

  always_ff @(posedge clk) begin
    if (prev_rst && !rst)
      assert_reset_svc_R1: assert (cur_status[MODE_W-1:0] == M_SVC);
  end

  assert_mode_legal_R10: assert property (@(posedge clk) disable iff (rst)
    mode_legal(cur_status[MODE_W-1:0]));

  assert_exc_switch_R7: assert property (@(posedge clk) disable iff (rst)
    (exc_go && mode_has_saved(exc_mode)) |=> cur_status[MODE_W-1:0] == $past(exc_mode));

  assert_exc_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (exc_go && !mode_has_saved(exc_mode) && !eret_go && !sr_wr_en) |=> $stable(cur_status));

  assert_eret_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (eret_go && !mode_has_saved(cur_status[MODE_W-1:0]) && !exc_go && !sr_wr_en)
      |=> $stable(cur_status));

  assert_bad_mode_R10: assert property (@(posedge clk) disable iff (rst)
    (sr_wr_en && !exc_go && !eret_go && !mode_legal(sr_wr_data[MODE_W-1:0]))
      |=> $stable(cur_status[MODE_W-1:0]));

  assert_pc_step_R11: assert property (@(posedge clk) disable iff (rst)
    (pc_inc && !pc_load) |=>
      pc_out == $past(pc_out) + ($past(cur_status[T_BIT]) ? STEP_NARROW : STEP_WIDE));

  assert_pc_load_R11: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> pc_out == $past(pc_load_val));
endmodule

bind bnk_regfile bnk_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .exc_go(exc_go), .exc_mode(exc_mode), .eret_go(eret_go),
  .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .pc_load(pc_load),
  .pc_load_val(pc_load_val), .pc_inc(pc_inc), .cur_status(cur_status), .pc_out(pc_out)
);

// File: tb/tb_bnk_regfile.sv
`timescale 1ns/1ps
module tb_bnk_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, sr_wr_data = '0;
  logic        wr_en = 0, sr_wr_en = 0, exc_go = 0, eret_go = 0, pc_load = 0, pc_inc = 0;
  logic [4:0]  exc_mode = '0;
  logic [31:0] exc_ret_addr = '0, pc_load_val = '0, cur_status, pc_out;

  int checks = 0, fails = 0;
  bit live = 0;

  always #10 clk = ~clk;

  bnk_regfile dut (.*);

  // ---------------- reference model ----------------
  logic [31:0] m_low [8];
  bit          k_low [8];
  logic [31:0] m_up  [6][7];
  bit          k_up  [6][7];
  logic [31:0] m_saved [5];
  logic [31:0] m_status, m_pc, e_a, e_b;
  bit          k_a, k_b;

  initial begin
    for (int i = 0; i < 8; i++) k_low[i] = 0;
    for (int b = 0; b < 6; b++) for (int i = 0; i < 7; i++) k_up[b][i] = 0;
  end

  function automatic int bank_of(input logic [4:0] m);
    case (m)
      5'h11: return 1; 5'h12: return 2; 5'h13: return 3;
      5'h17: return 4; 5'h1B: return 5; default: return 0;
    endcase
  endfunction

  function automatic bit legal(input logic [4:0] m);
    return m == 5'h10 || m == 5'h11 || m == 5'h12 || m == 5'h13 ||
           m == 5'h17 || m == 5'h1B || m == 5'h1F;
  endfunction

  function automatic bit excmode(input logic [4:0] m);
    return legal(m) && bank_of(m) != 0;
  endfunction

  task automatic m_read(input logic [3:0] idx, input logic [4:0] m,
                        output logic [31:0] v, output bit k);
    if (idx == 15) begin v = m_pc; k = 1; end
    else if (idx < 8) begin v = m_low[idx]; k = k_low[idx]; end
    else begin v = m_up[bank_of(m)][idx-8]; k = k_up[bank_of(m)][idx-8]; end
  endtask

  task automatic m_store(input logic [3:0] idx, input logic [4:0] m, input logic [31:0] v);
    if (idx < 8) begin m_low[idx] = v; k_low[idx] = 1; end
    else if (idx != 15) begin m_up[bank_of(m)][idx-8] = v; k_up[bank_of(m)][idx-8] = 1; end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_status = 32'h13; m_pc = 0;
      for (int s = 0; s < 5; s++) m_saved[s] = 32'h13;
      e_a = 0; e_b = 0; k_a = 1; k_b = 1;
      live <= 1;
    end else begin
      logic [31:0] old;
      logic [4:0]  om;
      old = m_status; om = old[4:0];
      m_read(rd_a_idx, om, e_a, k_a);
      m_read(rd_b_idx, om, e_b, k_b);
      if (wr_en && wr_idx != 15) m_store(wr_idx, om, wr_data);
      if (exc_go && excmode(exc_mode)) begin
        m_saved[bank_of(exc_mode)-1] = old;
        m_status = {old[31:5], exc_mode};
        m_store(4'd14, exc_mode, exc_ret_addr);
      end else if (eret_go && excmode(om))
        m_status = m_saved[bank_of(om)-1];
      else if (sr_wr_en)
        m_status = legal(sr_wr_data[4:0]) ? sr_wr_data : {sr_wr_data[31:5], om};
      if (pc_load) m_pc = pc_load_val;
      else if (pc_inc) m_pc = m_pc + (old[5] ? 32'd2 : 32'd4);
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk("R7 R10 status vs model", cur_status, m_status);
      chk("R11 pc vs model", pc_out, m_pc);
      if (k_a) chk("R5 port A vs model", rd_a_data, e_a);
      if (k_b) chk("R5 port B vs model", rd_b_data, e_b);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    wr_en = 0; sr_wr_en = 0; exc_go = 0; eret_go = 0; pc_load = 0; pc_inc = 0;
  endtask
  task automatic tick(); @(negedge clk); endtask
  task automatic set_sr(input logic [31:0] v);
    sr_wr_en = 1; sr_wr_data = v; tick(); idle();
  endtask
  task automatic wr(input logic [3:0] i, input logic [31:0] v);
    wr_en = 1; wr_idx = i; wr_data = v; tick(); idle();
  endtask
  task automatic rd(input logic [3:0] i, output logic [31:0] v);
    rd_a_idx = i; tick(); v = rd_a_data;
  endtask

  localparam logic [4:0] EXM [5] = '{5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};
  localparam logic [4:0] ANYM [8] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h06};

  initial begin
    logic [31:0] v;
    repeat (3) tick();
    rst = 0;
    chk("R1 status after reset", cur_status, 32'h13);
    chk("R1 pc after reset", pc_out, 32'h0);
    chk("R1 read A after reset", rd_a_data, 32'h0);

    set_sr(32'h10);
    for (int i = 0; i < 15; i++) wr(4'(i), 32'hA000_0000 + i);
    for (int j = 0; j < 5; j++) begin
      set_sr({27'h0, EXM[j]});
      for (int i = 8; i < 15; i++) wr(4'(i), 32'h0B00_0000 | (32'(EXM[j]) << 8) | i);
    end
    set_sr(32'h11);
    rd(4'd3, v);  chk("R2 shared r3 in FIQ", v, 32'hA000_0003);
    rd(4'd10, v); chk("R3 FIQ r10", v, 32'h0B00_110A);
    set_sr(32'h12);
    rd(4'd10, v); chk("R3 IRQ r10", v, 32'h0B00_120A);
    rd(4'd7, v);  chk("R2 shared r7 in IRQ", v, 32'hA000_0007);
    set_sr(32'h1F);
    rd(4'd13, v); chk("R4 System r13 is User r13", v, 32'hA000_000D);
    wr(4'd9, 32'h5555);
    set_sr(32'h10);
    rd(4'd9, v);  chk("R4 User sees System write", v, 32'h5555);

    wr_en = 1; wr_idx = 4'd5; wr_data = 32'h77; rd_a_idx = 4'd5; tick(); idle();
    chk("R5 no bypass on same-cycle write", rd_a_data, 32'hA000_0005);
    rd(4'd5, v); chk("R5 write visible next read", v, 32'h77);

    pc_load = 1; pc_load_val = 32'h1000; tick(); idle();
    rd(4'd15, v); chk("R5 index 15 reads pc", v, 32'h1000);
    wr(4'd15, 32'hDEAD);
    chk("R6 write to 15 ignored", pc_out, 32'h1000);
    pc_inc = 1; tick(); idle();
    chk("R11 step by 4", pc_out, 32'h1004);
    set_sr(32'h30);
    pc_inc = 1; tick(); idle();
    chk("R11 step by 2 in narrow state", pc_out, 32'h1006);
    pc_load = 1; pc_inc = 1; pc_load_val = 32'h2000; tick(); idle();
    chk("R11 load beats step", pc_out, 32'h2000);
    set_sr(32'h10);

    exc_go = 1; exc_mode = 5'h12; exc_ret_addr = 32'h1234;
    wr_en = 1; wr_idx = 4'd14; wr_data = 32'h99; sr_wr_en = 1; sr_wr_data = 32'h1B;
    tick(); idle();
    chk("R7 entry switches mode over status write", cur_status, 32'h12);
    rd(4'd14, v); chk("R7 link register of target", v, 32'h1234);
    eret_go = 1; tick(); idle();
    chk("R9 return restores saved", cur_status, 32'h10);
    rd(4'd14, v); chk("R7 same-cycle write used old bank", v, 32'h99);

    exc_go = 1; exc_mode = 5'h1F; tick(); idle();
    chk("R8 System target ignored", cur_status, 32'h10);
    exc_go = 1; exc_mode = 5'h05; tick(); idle();
    chk("R8 illegal target ignored", cur_status, 32'h10);
    set_sr(32'h1F);
    eret_go = 1; tick(); idle();
    chk("R9 return in System ignored", cur_status, 32'h1F);
    set_sr(32'h8000_0005);
    chk("R10 illegal mode keeps mode", cur_status, 32'h8000_001F);
    set_sr(32'h13);
    chk("R10 legal write", cur_status, 32'h13);

    exc_go = 1; exc_mode = 5'h17; exc_ret_addr = 32'h40; tick(); idle();
    exc_go = 1; exc_mode = 5'h1B; exc_ret_addr = 32'h80; tick(); idle();
    chk("R7 nested entry", cur_status, 32'h1B);
    eret_go = 1; tick(); idle();
    chk("R9 unwind to Abort", cur_status, 32'h17);
    rd(4'd14, v); chk("R7 Abort link register", v, 32'h40);
    eret_go = 1; tick(); idle();
    chk("R9 unwind to Supervisor", cur_status, 32'h13);

    for (int n = 0; n < 600; n++) begin
      rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
      wr_en = ($urandom % 2) == 0; wr_idx = 4'($urandom); wr_data = $urandom;
      exc_go = ($urandom % 8) == 0; exc_mode = ANYM[$urandom % 8]; exc_ret_addr = $urandom;
      eret_go = ($urandom % 8) == 0;
      sr_wr_en = ($urandom % 8) == 0;
      sr_wr_data = {($urandom) & 32'hFFFF_FFE0} | 32'(ANYM[$urandom % 8]);
      pc_load = ($urandom % 16) == 0; pc_load_val = $urandom; pc_inc = ($urandom % 2) == 0;
      tick();
    end
    idle(); tick(); tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule